// File: doc/BRIEF.md
# Dual-Port Pin Override Controller

This block drives two 8-pin general-purpose ports, A and B, for a microcontroller-class chip. Software writes a data register and a direction register for each port. A single global bit switches off all pull-ups. A global input-disable bit can turn off the digital input buffers. For each pin the block computes four pad controls: pull-up enable, output enable, output value and digital-input enable. It also synchronises the pad level and returns it to software and to the peripherals.

Peripherals can take over pins from the registers. On port A these are a boundary-scan test port, a two-wire serial bus and an asynchronous timer crystal. On port B they are timer compare outputs, a capture input, a UART and two external interrupts. Each pin holds an enable/value pair for each of the four pad controls. A peripheral enable sets the enable half of that pair. When the enable is clear, the pin falls back to register-driven behaviour. Analog pad features appear only as these digital controls.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset both data registers and both direction registers hold zero, so every pin is an input with its pull-up off and output enable low.
- R2: A pin with no active override drives output enable equal to its direction bit and output value equal to its data bit. Its pull-up is on only when the pin is an input with data bit 1 and `pud_all` low.
- R3: A write with `reg_wr` high loads `reg_wdata` on the next rising edge. The target is chosen by `reg_sel`: 0 selects port A data, 1 port A direction, 2 port B data and 3 port B direction.
- R4: A pad level reaches `pin_a_rd`/`pin_b_rd` and the synchronised peripheral inputs through two flops. A change applied before rising edge k is visible after edge k+1 and not after edge k.
- R5: A pin whose digital-input enable is low reads back 0. With no override, that enable is the inverse of `dig_in_off`.
- R6: With `tap_en` high, port A bits 5, 3 and 2 have output enable low, pull-up forced on and digital input disabled. Bit 4 has its pull-up forced off and its digital input disabled. The scan inputs `tap_tdi`, `tap_tms` and `tap_tck` follow pad bits 5, 3 and 2 without synchronisation.
- R7: With `tap_en` high, port A bit 4 outputs `tap_tdo` and is enabled only while `tap_shift` is high. At all other times it is tri-stated.
- R8: With `osc_async_en` high, port A bits 7 and 6 have pull-up, output enable and digital-input enable all forced low.
- R9: With `twi_en` high, port A bits 1 and 0 output 0 with output enable equal to `twi_sda_low` and `twi_scl_low` respectively. Their pull-up equals the data bit AND NOT `pud_all`, whatever the direction bit. `twi_sda_in` and `twi_scl_in` carry the synchronised pad levels.
- R10: With `tx_en` high, port B bit 1 is an output carrying `tx_data` regardless of its direction bit, with its pull-up off.
- R11: With `rx_en` high, port B bit 0 is an input regardless of its direction bit. Its pull-up equals data bit AND NOT `pud_all`. `rx_data` carries its synchronised level.
- R12: `int0_en` forces the digital-input enable of port B bit 2 high, and `int1_en` does the same for bit 3, even while `dig_in_off` is high. `int0_in` and `int1_in` carry those pins' synchronised levels.
- R13: `cmp2_en`, `cmp1a_en` and `cmp1b_en` replace only the output value of port B bits 7, 5 and 4 with `cmp2_val`, `cmp1a_val` and `cmp1b_val`. The output enable stays equal to the direction bit.
- R14: `icp_in` carries the synchronised level of port B bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 A data, 1 A dir, 2 B data, 3 B dir) |
| reg_wdata | input | 8 | Register write data |
| pud_all | input | 1 | Global pull-up disable |
| dig_in_off | input | 1 | Global digital-input disable |
| tap_en | input | 1 | Test port enable |
| tap_shift | input | 1 | Test controller is in a shift state |
| tap_tdo | input | 1 | Test serial output bit |
| osc_async_en | input | 1 | Asynchronous timer crystal select |
| twi_en | input | 1 | Two-wire bus enable |
| twi_sda_low | input | 1 | Two-wire data line pull-low request |
| twi_scl_low | input | 1 | Two-wire clock line pull-low request |
| tx_en | input | 1 | UART transmitter enable |
| tx_data | input | 1 | UART transmit bit |
| rx_en | input | 1 | UART receiver enable |
| int0_en | input | 1 | External interrupt 0 enable |
| int1_en | input | 1 | External interrupt 1 enable |
| cmp2_en | input | 1 | Compare output 2 enable |
| cmp2_val | input | 1 | Compare output 2 level |
| cmp1a_en | input | 1 | Compare output 1A enable |
| cmp1a_val | input | 1 | Compare output 1A level |
| cmp1b_en | input | 1 | Compare output 1B enable |
| cmp1b_val | input | 1 | Compare output 1B level |
| pad_a_in | input | 8 | Port A pad levels |
| pad_b_in | input | 8 | Port B pad levels |
| pad_a_oe | output | 8 | Port A output enables |
| pad_a_out | output | 8 | Port A output values |
| pad_a_pu | output | 8 | Port A pull-up enables |
| pad_a_die | output | 8 | Port A digital-input enables |
| pad_b_oe | output | 8 | Port B output enables |
| pad_b_out | output | 8 | Port B output values |
| pad_b_pu | output | 8 | Port B pull-up enables |
| pad_b_die | output | 8 | Port B digital-input enables |
| pin_a_rd | output | 8 | Port A synchronised read-back |
| pin_b_rd | output | 8 | Port B synchronised read-back |
| tap_tdi | output | 1 | Scan data input |
| tap_tms | output | 1 | Scan mode select |
| tap_tck | output | 1 | Scan clock |
| twi_sda_in | output | 1 | Two-wire data line level |
| twi_scl_in | output | 1 | Two-wire clock line level |
| rx_data | output | 1 | UART receive level |
| int0_in | output | 1 | Interrupt 0 pin level |
| int1_in | output | 1 | Interrupt 1 pin level |
| icp_in | output | 1 | Capture pin level |

## Verification
The plain-register path is driven with mixed direction and data patterns, once with pull-ups allowed and once with them disabled. This separates the pull-up rule from the output path. Each peripheral enable is then raised over register contents chosen so that the overridden control differs from what the registers alone would give. The receive pin has its direction bit set and the two-wire pins have theirs set; only a real override yields the expected pad value. The read path is sampled one edge and two edges after a pad change to pin down the latency. It is also sampled with the global input disable set, which shows that interrupt pins stay alive while other pins read zero.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  localparam int PIN_W = 8;

  // Port A pin roles
  localparam int A_XTAL_O = 7;
  localparam int A_XTAL_I = 6;
  localparam int A_TDI    = 5;
  localparam int A_TDO    = 4;
  localparam int A_TMS    = 3;
  localparam int A_TCK    = 2;
  localparam int A_SDA    = 1;
  localparam int A_SCL    = 0;

  // Port B pin roles
  localparam int B_CMP2  = 7;
  localparam int B_ICP   = 6;
  localparam int B_CMP1A = 5;
  localparam int B_CMP1B = 4;
  localparam int B_INT1  = 3;
  localparam int B_INT0  = 2;
  localparam int B_TX    = 1;
  localparam int B_RX    = 0;

  // Enable/value pairs for each pad control of one pin
  typedef struct packed {
    logic pu_oe;
    logic pu_ov;
    logic dir_oe;
    logic dir_ov;
    logic val_oe;
    logic val_ov;
    logic die_oe;
    logic die_ov;
  } pin_ovr_t;

  typedef struct packed {
    logic pu;
    logic oe;
    logic out;
    logic die;
  } pin_drv_t;

  // Final pad controls of one pin
  function automatic pin_drv_t resolve_pin(pin_ovr_t o, logic data, logic dir,
                                           logic pud, logic din_off);
    pin_drv_t r;
    r.oe  = o.dir_oe ? o.dir_ov : dir;
    r.out = o.val_oe ? o.val_ov : data;
    r.pu  = o.pu_oe  ? o.pu_ov  : (data & ~dir & ~pud);
    r.die = o.die_oe ? o.die_ov : ~din_off;
    return r;
  endfunction

  // Peripheral takes the pin entirely and isolates it
  function automatic pin_ovr_t isolate(logic en, logic pu_v);
    pin_ovr_t o;
    o = '0;
    o.pu_oe  = en;
    o.pu_ov  = pu_v;
    o.dir_oe = en;
    o.die_oe = en;
    return o;
  endfunction

endpackage

// File: rtl/gpio_ovr_map.sv
module gpio_ovr_map
  import gpio_ovr_pkg::*;
(
  input  logic       tap_en,
  input  logic       tap_shift,
  input  logic       tap_tdo,
  input  logic       osc_async_en,
  input  logic       twi_en,
  input  logic       twi_sda_low,
  input  logic       twi_scl_low,
  input  logic [1:0] twi_data_bits,
  input  logic       tx_en,
  input  logic       tx_data,
  input  logic       rx_en,
  input  logic       rx_data_bit,
  input  logic       int0_en,
  input  logic       int1_en,
  input  logic       cmp2_en,
  input  logic       cmp2_val,
  input  logic       cmp1a_en,
  input  logic       cmp1a_val,
  input  logic       cmp1b_en,
  input  logic       cmp1b_val,
  input  logic       pud,
  output pin_ovr_t   ovr_a [PIN_W],
  output pin_ovr_t   ovr_b [PIN_W]
);

  always_comb begin
    for (int i = 0; i < PIN_W; i++) begin
      ovr_a[i] = '0;
      ovr_b[i] = '0;
    end
    // crystal pins
    ovr_a[A_XTAL_O] = isolate(osc_async_en, 1'b0);
    ovr_a[A_XTAL_I] = isolate(osc_async_en, 1'b0);
    // scan port
    ovr_a[A_TDI] = isolate(tap_en, 1'b1);
    ovr_a[A_TMS] = isolate(tap_en, 1'b1);
    ovr_a[A_TCK] = isolate(tap_en, 1'b1);
    ovr_a[A_TDO] = isolate(tap_en, 1'b0);
    ovr_a[A_TDO].dir_ov = tap_shift;
    ovr_a[A_TDO].val_oe = tap_en;
    ovr_a[A_TDO].val_ov = tap_tdo;
    // two-wire bus: open drain, pull-up from data bit
    ovr_a[A_SDA].pu_oe  = twi_en;
    ovr_a[A_SDA].pu_ov  = twi_data_bits[1] & ~pud;
    ovr_a[A_SDA].dir_oe = twi_en;
    ovr_a[A_SDA].dir_ov = twi_sda_low;
    ovr_a[A_SDA].val_oe = twi_en;
    ovr_a[A_SCL].pu_oe  = twi_en;
    ovr_a[A_SCL].pu_ov  = twi_data_bits[0] & ~pud;
    ovr_a[A_SCL].dir_oe = twi_en;
    ovr_a[A_SCL].dir_ov = twi_scl_low;
    ovr_a[A_SCL].val_oe = twi_en;
    // compare outputs: value only
    ovr_b[B_CMP2].val_oe  = cmp2_en;
    ovr_b[B_CMP2].val_ov  = cmp2_val;
    ovr_b[B_CMP1A].val_oe = cmp1a_en;
    ovr_b[B_CMP1A].val_ov = cmp1a_val;
    ovr_b[B_CMP1B].val_oe = cmp1b_en;
    ovr_b[B_CMP1B].val_ov = cmp1b_val;
    // interrupts keep the input buffer alive
    ovr_b[B_INT1].die_oe = int1_en;
    ovr_b[B_INT1].die_ov = 1'b1;
    ovr_b[B_INT0].die_oe = int0_en;
    ovr_b[B_INT0].die_ov = 1'b1;
    // UART
    ovr_b[B_TX].pu_oe  = tx_en;
    ovr_b[B_TX].dir_oe = tx_en;
    ovr_b[B_TX].dir_ov = 1'b1;
    ovr_b[B_TX].val_oe = tx_en;
    ovr_b[B_TX].val_ov = tx_data;
    ovr_b[B_RX].pu_oe  = rx_en;
    ovr_b[B_RX].pu_ov  = rx_data_bit & ~pud;
    ovr_b[B_RX].dir_oe = rx_en;
  end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_ovr_pkg::*;
(
  input  pin_ovr_t ovr,
  input  logic     data,
  input  logic     dir,
  input  logic     pud,
  input  logic     din_off,
  output pin_drv_t drv
);

  assign drv = resolve_pin(ovr, data, dir, pud, din_off);

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic die,
  output logic rd
);

  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= {q[STAGES-2:0], raw};
  end

  assign rd = q[STAGES-1] & die;

  generate
    if (STAGES == 2) begin : g_lat_chk
      // R4
      sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q[STAGES-1]) |-> $past(raw, 2));
    end
  endgenerate

endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
  import gpio_ovr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [PIN_W-1:0] reg_wdata,
  input  logic             pud_all,
  input  logic             dig_in_off,
  input  logic             tap_en,
  input  logic             tap_shift,
  input  logic             tap_tdo,
  input  logic             osc_async_en,
  input  logic             twi_en,
  input  logic             twi_sda_low,
  input  logic             twi_scl_low,
  input  logic             tx_en,
  input  logic             tx_data,
  input  logic             rx_en,
  input  logic             int0_en,
  input  logic             int1_en,
  input  logic             cmp2_en,
  input  logic             cmp2_val,
  input  logic             cmp1a_en,
  input  logic             cmp1a_val,
  input  logic             cmp1b_en,
  input  logic             cmp1b_val,
  input  logic [PIN_W-1:0] pad_a_in,
  input  logic [PIN_W-1:0] pad_b_in,
  output logic [PIN_W-1:0] pad_a_oe,
  output logic [PIN_W-1:0] pad_a_out,
  output logic [PIN_W-1:0] pad_a_pu,
  output logic [PIN_W-1:0] pad_a_die,
  output logic [PIN_W-1:0] pad_b_oe,
  output logic [PIN_W-1:0] pad_b_out,
  output logic [PIN_W-1:0] pad_b_pu,
  output logic [PIN_W-1:0] pad_b_die,
  output logic [PIN_W-1:0] pin_a_rd,
  output logic [PIN_W-1:0] pin_b_rd,
  output logic             tap_tdi,
  output logic             tap_tms,
  output logic             tap_tck,
  output logic             twi_sda_in,
  output logic             twi_scl_in,
  output logic             rx_data,
  output logic             int0_in,
  output logic             int1_in,
  output logic             icp_in
);

  localparam logic [1:0] SEL_A_DATA = 2'd0;
  localparam logic [1:0] SEL_A_DIR  = 2'd1;
  localparam logic [1:0] SEL_B_DATA = 2'd2;
  localparam logic [1:0] SEL_B_DIR  = 2'd3;

  logic [PIN_W-1:0] data_a, dir_a, data_b, dir_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_a <= '0;
      dir_a  <= '0;
      data_b <= '0;
      dir_b  <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        SEL_A_DATA: data_a <= reg_wdata;
        SEL_A_DIR:  dir_a  <= reg_wdata;
        SEL_B_DATA: data_b <= reg_wdata;
        SEL_B_DIR:  dir_b  <= reg_wdata;
        default: ;
      endcase
    end
  end

  pin_ovr_t ovr_a [PIN_W];
  pin_ovr_t ovr_b [PIN_W];

  gpio_ovr_map u_map (
    .tap_en        (tap_en),
    .tap_shift     (tap_shift),
    .tap_tdo       (tap_tdo),
    .osc_async_en  (osc_async_en),
    .twi_en        (twi_en),
    .twi_sda_low   (twi_sda_low),
    .twi_scl_low   (twi_scl_low),
    .twi_data_bits ({data_a[A_SDA], data_a[A_SCL]}),
    .tx_en         (tx_en),
    .tx_data       (tx_data),
    .rx_en         (rx_en),
    .rx_data_bit   (data_b[B_RX]),
    .int0_en       (int0_en),
    .int1_en       (int1_en),
    .cmp2_en       (cmp2_en),
    .cmp2_val      (cmp2_val),
    .cmp1a_en      (cmp1a_en),
    .cmp1a_val     (cmp1a_val),
    .cmp1b_en      (cmp1b_en),
    .cmp1b_val     (cmp1b_val),
    .pud           (pud_all),
    .ovr_a         (ovr_a),
    .ovr_b         (ovr_b)
  );

  pin_drv_t drv_a [PIN_W];
  pin_drv_t drv_b [PIN_W];

  generate
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      gpio_pin_drive u_drv_a (
        .ovr(ovr_a[i]), .data(data_a[i]), .dir(dir_a[i]),
        .pud(pud_all), .din_off(dig_in_off), .drv(drv_a[i]));
      gpio_pin_drive u_drv_b (
        .ovr(ovr_b[i]), .data(data_b[i]), .dir(dir_b[i]),
        .pud(pud_all), .din_off(dig_in_off), .drv(drv_b[i]));

      assign pad_a_oe[i]  = drv_a[i].oe;
      assign pad_a_out[i] = drv_a[i].out;
      assign pad_a_pu[i]  = drv_a[i].pu;
      assign pad_a_die[i] = drv_a[i].die;
      assign pad_b_oe[i]  = drv_b[i].oe;
      assign pad_b_out[i] = drv_b[i].out;
      assign pad_b_pu[i]  = drv_b[i].pu;
      assign pad_b_die[i] = drv_b[i].die;

      gpio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .raw(pad_a_in[i]),
        .die(drv_a[i].die), .rd(pin_a_rd[i]));
      gpio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .raw(pad_b_in[i]),
        .die(drv_b[i].die), .rd(pin_b_rd[i]));
    end
  endgenerate

  // scan pins bypass the synchroniser; the scan logic runs on its own clock
  assign tap_tdi    = pad_a_in[A_TDI];
  assign tap_tms    = pad_a_in[A_TMS];
  assign tap_tck    = pad_a_in[A_TCK];
  assign twi_sda_in = pin_a_rd[A_SDA];
  assign twi_scl_in = pin_a_rd[A_SCL];
  assign rx_data    = pin_b_rd[B_RX];
  assign int0_in    = pin_b_rd[B_INT0];
  assign int1_in    = pin_b_rd[B_INT1];
  assign icp_in     = pin_b_rd[B_ICP];

  // R7
  tdo_idle_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_en && !tap_shift) |-> !pad_a_oe[A_TDO]);

  // R8
  xtal_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_async_en |-> (pad_a_oe[7:6] == 2'b00 && pad_a_pu[7:6] == 2'b00
                      && pad_a_die[7:6] == 2'b00));

  // R9
  twi_open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    twi_en |-> (pad_a_out[1:0] == 2'b00));

  // R10
  tx_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (pad_b_oe[B_TX] && !pad_b_pu[B_TX]));

  // R12
  int_input_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int0_en |-> pad_b_die[B_INT0]) and (int1_en |-> pad_b_die[B_INT1]));

endmodule

// File: tb/tb_gpio_altfn_port.sv
`timescale 1ns/1ps
module tb_gpio_altfn_port;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic pud_all = 0, dig_in_off = 0;
  logic tap_en = 0, tap_shift = 0, tap_tdo = 0, osc_async_en = 0;
  logic twi_en = 0, twi_sda_low = 0, twi_scl_low = 0;
  logic tx_en = 0, tx_data = 0, rx_en = 0, int0_en = 0, int1_en = 0;
  logic cmp2_en = 0, cmp2_val = 0, cmp1a_en = 0, cmp1a_val = 0, cmp1b_en = 0, cmp1b_val = 0;
  logic [7:0] pad_a_in = '0, pad_b_in = '0;
  logic [7:0] pad_a_oe, pad_a_out, pad_a_pu, pad_a_die;
  logic [7:0] pad_b_oe, pad_b_out, pad_b_pu, pad_b_die;
  logic [7:0] pin_a_rd, pin_b_rd;
  logic tap_tdi, tap_tms, tap_tck, twi_sda_in, twi_scl_in, rx_data, int0_in, int1_in, icp_in;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_altfn_port dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic two_edges();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    @(negedge clk);
    pud_all = 0; dig_in_off = 0; tap_en = 0; tap_shift = 0; tap_tdo = 0;
    osc_async_en = 0; twi_en = 0; twi_sda_low = 0; twi_scl_low = 0;
    tx_en = 0; tx_data = 0; rx_en = 0; int0_en = 0; int1_en = 0;
    cmp2_en = 0; cmp2_val = 0; cmp1a_en = 0; cmp1a_val = 0; cmp1b_en = 0; cmp1b_val = 0;
    pad_a_in = '0; pad_b_in = '0;
    for (int s = 0; s < 4; s++) wr(2'(s), 8'h00);
    two_edges();
  endtask

  task automatic t_reset();
    check("R1 oe A", pad_a_oe, 8'h00);
    check("R1 oe B", pad_b_oe, 8'h00);
    check("R1 pu A", pad_a_pu, 8'h00);
    check("R1 pu B", pad_b_pu, 8'h00);
  endtask

  task automatic t_plain();
    wr(2'd1, 8'hF0); wr(2'd0, 8'hAA);
    wr(2'd3, 8'h0F); wr(2'd2, 8'h35);
    check("R2 R3 oe A", pad_a_oe, 8'hF0);
    check("R2 R3 out A", pad_a_out, 8'hAA);
    check("R2 pu A", pad_a_pu, 8'h0A);
    check("R2 R3 oe B", pad_b_oe, 8'h0F);
    check("R2 R3 out B", pad_b_out, 8'h35);
    check("R2 pu B", pad_b_pu, 8'h30);
    pud_all = 1'b1; #1;
    check("R2 pud A", pad_a_pu, 8'h00);
    check("R2 pud B", pad_b_pu, 8'h00);
    quiet();
  endtask

  task automatic t_sync();
    @(negedge clk);
    pad_a_in = 8'h5C;
    @(posedge clk); @(negedge clk);
    check("R4 one edge", pin_a_rd, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R4 two edges", pin_a_rd, 8'h5C);
    check("R5 die on", pad_a_die, 8'hFF);
    dig_in_off = 1'b1; #1;
    check("R5 read gated", pin_a_rd, 8'h00);
    check("R5 die off", pad_a_die, 8'h00);
    quiet();
  endtask

  task automatic t_tap();
    wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
    tap_en = 1'b1; tap_shift = 1'b0; tap_tdo = 1'b1; #1;
    check("R6 pu", pad_a_pu, 8'h2C);
    check("R6 R7 oe idle", pad_a_oe, 8'hC3);
    check("R6 die", pad_a_die, 8'hC3);
    check("R7 tdo value", {7'b0, pad_a_out[4]}, 8'h01);
    tap_shift = 1'b1; #1;
    check("R7 oe shifting", pad_a_oe, 8'hD3);
    pad_a_in = 8'h24; #1;
    check("R6 raw scan in", {5'b0, tap_tdi, tap_tms, tap_tck}, 8'h05);
    pad_a_in = 8'hFF;
    two_edges();
    check("R6 read gated", pin_a_rd, 8'hC3);
    quiet();
  endtask

  task automatic t_osc();
    wr(2'd0, 8'hC0);
    osc_async_en = 1'b1; #1;
    check("R8 pu", pad_a_pu, 8'h00);
    check("R8 die", pad_a_die, 8'h3F);
    wr(2'd1, 8'hC0);
    check("R8 oe", pad_a_oe, 8'h00);
    quiet();
  endtask

  task automatic t_twi();
    wr(2'd0, 8'h03);
    twi_en = 1'b1; twi_sda_low = 1'b1; twi_scl_low = 1'b0; #1;
    check("R9 oe", pad_a_oe, 8'h02);
    check("R9 out", pad_a_out, 8'h00);
    check("R9 pu", pad_a_pu, 8'h03);
    wr(2'd1, 8'h03);
    check("R9 oe dir set", pad_a_oe, 8'h02);
    check("R9 pu dir set", pad_a_pu, 8'h03);
    pud_all = 1'b1; #1;
    check("R9 pu disabled", pad_a_pu, 8'h00);
    pad_a_in = 8'h02;
    two_edges();
    check("R9 line in", {6'b0, twi_sda_in, twi_scl_in}, 8'h02);
    quiet();
  endtask

  task automatic t_uart();
    wr(2'd2, 8'h03);
    tx_en = 1'b1; tx_data = 1'b0; #1;
    check("R10 oe", {7'b0, pad_b_oe[1]}, 8'h01);
    check("R10 out low", {7'b0, pad_b_out[1]}, 8'h00);
    check("R10 pu", {7'b0, pad_b_pu[1]}, 8'h00);
    tx_data = 1'b1; #1;
    check("R10 out high", {7'b0, pad_b_out[1]}, 8'h01);
    wr(2'd3, 8'h01);
    rx_en = 1'b1; #1;
    check("R11 oe", {7'b0, pad_b_oe[0]}, 8'h00);
    check("R11 pu", {7'b0, pad_b_pu[0]}, 8'h01);
    pud_all = 1'b1; #1;
    check("R11 pu disabled", {7'b0, pad_b_pu[0]}, 8'h00);
    pad_b_in = 8'h01;
    two_edges();
    check("R11 rx in", {7'b0, rx_data}, 8'h01);
    quiet();
  endtask

  task automatic t_int();
    dig_in_off = 1'b1; int0_en = 1'b1; #1;
    check("R12 die", pad_b_die, 8'h04);
    pad_b_in = 8'h4C;
    two_edges();
    check("R12 read", pin_b_rd, 8'h04);
    check("R12 int pins", {6'b0, int1_in, int0_in}, 8'h01);
    dig_in_off = 1'b0; #1;
    check("R14 capture in", {7'b0, icp_in}, 8'h01);
    quiet();
  endtask

  task automatic t_cmp();
    cmp1a_en = 1'b1; cmp1a_val = 1'b1; #1;
    check("R13 value", pad_b_out, 8'h20);
    check("R13 oe held", pad_b_oe, 8'h00);
    wr(2'd3, 8'h20);
    check("R13 oe dir", pad_b_oe, 8'h20);
    cmp2_en = 1'b1; cmp2_val = 1'b1; cmp1b_en = 1'b1; cmp1b_val = 1'b0; #1;
    check("R13 all", pad_b_out, 8'hA0);
    quiet();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_sync();
    t_tap();
    t_osc();
    t_twi();
    t_uart();
    t_int();
    t_cmp();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule